// File: doc/BRIEF.md
# Compact vector-instruction prefix encoder

This block turns the decoded fields of one vector instruction into the prefix bytes that precede its opcode, and then the opcode byte itself. Its output is a byte stream with valid/ready flow control. The inputs are:

- the opcode map code, the W bit, the vector-length bit and the implied-prefix code;
- the 4-bit second-source register number;
- bit 3 of the register numbers for the reg, index and base operands;
- the opcode.

For every instruction the block checks whether the compact two-byte prefix is legal. If it is not, the block uses the general three-byte prefix. Register-number extension bits are written into the prefix inverted, and so is the second-source field. The block reports the total number of bytes it emits, counting the opcode. Bytes for operand addressing, displacements and immediates are produced elsewhere.

An upstream formatter presents one instruction at a time. A downstream byte packer takes the stream. The packer uses the last flag to find the opcode byte, and the length output to reserve space before the stream ends.

Top module: `vpfx_encoder`

## Requirements
- R1: The first byte is 0xC5 (short form) exactly when the map code is 1, W is 0, the index extension bit is 0 and the base extension bit is 0. Otherwise the first byte is 0xC4 (long form).
- R2: A short-form stream is 0xC5, then {~reg_ext, ~src2[3:0], L, pp[1:0]} (bit 7 down to bit 0), then the opcode.
- R3: A long-form stream is 0xC4, then {~reg_ext, ~idx_ext, ~base_ext, map[4:0]}, then {W, ~src2[3:0], L, pp[1:0]}, then the opcode.
- R4: The reg extension bit is stored inverted and never forces the long form. For example, map 1, W 0, reg_ext 1, src2 0, L 0, pp 1 gives the middle byte 0x79.
- R5: out_len is 3 for every byte of a short-form stream and 4 for every byte of a long-form stream.
- R6: out_last is 1 on the opcode byte only.
- R7: While out_valid is 1 and out_ready is 0, out_data, out_last and out_len keep their values.
- R8: in_ready is 1 only when no stream is in progress. It goes low in the cycle after an accept and returns high in the cycle after the opcode byte is taken.
- R9: A map code of 0 or of 4 to 31 is accepted, raises in_err for exactly the next cycle, and produces no output bytes.
- R10: After reset, out_valid is 0, in_ready is 1 and in_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction fields are valid |
| in_ready | output | 1 | Encoder idle, fields accepted on this edge |
| in_map | input | 5 | Opcode map code (1, 2 or 3 are legal) |
| in_w | input | 1 | W bit |
| in_l | input | 1 | Vector-length bit |
| in_pp | input | 2 | Implied-prefix code |
| in_src2 | input | 4 | Second-source register number |
| in_reg_ext | input | 1 | Bit 3 of the reg-field register number |
| in_idx_ext | input | 1 | Bit 3 of the index register number |
| in_base_ext | input | 1 | Bit 3 of the base/rm register number |
| in_opcode | input | 8 | Opcode byte |
| in_err | output | 1 | One-cycle pulse after an illegal map code is accepted |
| out_valid | output | 1 | out_data holds a byte |
| out_ready | input | 1 | Consumer takes the byte on this edge |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Current byte is the opcode |
| out_len | output | 3 | Total stream length, 3 or 4 |

## Verification
The bench builds the block with its default parameters: a 5-bit map code, 8-bit bytes and a buffer of four bytes. These defaults cover both stream lengths and every map code from 0 to 31, so both the legal and the illegal maps can be tested.

The vector table varies one condition at a time: W, the index extension and the base extension each force the long form on their own, while the reg extension does not. The table also includes both legal long maps and an all-ones field case, so every inverted field position is visible in the stream. Directed tests cover back-pressure at the first byte, the idle gap that separates instructions, and illegal maps at both ends of the code range.

// File: rtl/vpfx_pkg.sv
// Package for the vector prefix encoder.
// Holds the field widths, the lead-byte values, the map codes and the
// instruction record passed between the submodules.
package vpfx_pkg;
    localparam int MAP_W     = 5;
    localparam int VREG_W    = 4;
    localparam int PP_W      = 2;
    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 4;
    localparam int LEN_W     = $clog2(MAX_BYTES + 1);
    localparam int IDX_W     = $clog2(MAX_BYTES);

    localparam logic [BYTE_W-1:0] LEAD_LONG  = 8'hC4;
    localparam logic [BYTE_W-1:0] LEAD_SHORT = 8'hC5;

    localparam logic [MAP_W-1:0] MAP_0F   = 5'd1;
    localparam logic [MAP_W-1:0] MAP_0F38 = 5'd2;
    localparam logic [MAP_W-1:0] MAP_0F3A = 5'd3;

    typedef struct packed {
        logic [MAP_W-1:0]  map;
        logic              w;
        logic              l;
        logic [PP_W-1:0]   pp;
        logic [VREG_W-1:0] src2;
        logic              reg_ext;
        logic              idx_ext;
        logic              base_ext;
        logic [BYTE_W-1:0] opc;
    } instr_t;
endpackage

// File: rtl/vpfx_form_sel.sv
// Form selector for the prefix encoder (purely combinational).
// Decides whether the compact form is legal and assembles the full byte
// list for the chosen form. Bytes beyond the chosen length are zero.
// Assumes the extension inputs are the plain (non-inverted) bit 3 of each
// register number.
module vpfx_form_sel
    import vpfx_pkg::*;
(
    input  instr_t                              instr,
    output logic                                map_ok,
    output logic                                short_ok,
    output logic [MAX_BYTES-1:0][BYTE_W-1:0]    bytes,
    output logic [LEN_W-1:0]                    len
);
    logic [BYTE_W-1:0] short_mid;
    logic [BYTE_W-1:0] long_b1;
    logic [BYTE_W-1:0] long_b2;

    // Map legality and the compact-form condition.
    always_comb begin
        map_ok   = (instr.map == MAP_0F) || (instr.map == MAP_0F38) ||
                   (instr.map == MAP_0F3A);
        short_ok = (instr.map == MAP_0F) && !instr.w &&
                   !instr.idx_ext && !instr.base_ext;
    end

    // Field packing of the candidate bytes, with extensions inverted.
    always_comb begin
        short_mid = {~instr.reg_ext, ~instr.src2, instr.l, instr.pp};
        long_b1   = {~instr.reg_ext, ~instr.idx_ext, ~instr.base_ext, instr.map};
        long_b2   = {instr.w, ~instr.src2, instr.l, instr.pp};
    end

    // Final byte list and length for the chosen form.
    always_comb begin
        if (short_ok) begin
            bytes[0] = LEAD_SHORT;
            bytes[1] = short_mid;
            bytes[2] = instr.opc;
            bytes[3] = '0;
            len      = LEN_W'(3);
        end else begin
            bytes[0] = LEAD_LONG;
            bytes[1] = long_b1;
            bytes[2] = long_b2;
            bytes[3] = instr.opc;
            len      = LEN_W'(4);
        end
    end
endmodule

// File: rtl/vpfx_byte_seq.sv
// Byte sequencer for the prefix encoder.
// Captures a byte list on load and presents the bytes one at a time with
// valid/ready flow control. The last flag marks the final byte.
// Assumes load is raised only while busy is low.
module vpfx_byte_seq
    import vpfx_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load,
    input  logic [MAX_BYTES-1:0][BYTE_W-1:0]  bytes,
    input  logic [LEN_W-1:0]                  len,
    output logic                              busy,
    output logic                              out_valid,
    input  logic                              out_ready,
    output logic [BYTE_W-1:0]                 out_data,
    output logic                              out_last,
    output logic [LEN_W-1:0]                  out_len
);
    logic [BYTE_W-1:0] buf_q [MAX_BYTES];
    logic [IDX_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_q;
    logic              busy_q;
    logic              take;

    // One capture register per byte slot.
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
        // Capture slot g when a new list is loaded.
        always_ff @(posedge clk) begin
            if (!rst_n)    buf_q[g] <= '0;
            else if (load) buf_q[g] <= bytes[g];
        end
    end

    // Decode the current position and the handshake.
    always_comb begin
        out_last = ({1'b0, idx_q} == (len_q - LEN_W'(1)));
        take     = busy_q && out_ready;
    end

    // Track the position within the stream and the busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            len_q  <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            len_q  <= len;
        end else if (take) begin
            if (out_last) busy_q <= 1'b0;
            else          idx_q  <= idx_q + IDX_W'(1);
        end
    end

    // Drive the stream outputs.
    always_comb begin
        busy      = busy_q;
        out_valid = busy_q;
        out_data  = buf_q[idx_q];
        out_len   = len_q;
    end
endmodule

// File: rtl/vpfx_encoder.sv
// Top level of the compact vector-instruction prefix encoder.
// Accepts one instruction while idle. A legal map starts a 3- or 4-byte
// stream. An illegal map raises in_err for one cycle and starts nothing.
module vpfx_encoder
    import vpfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [4:0]        in_map,
    input  logic              in_w,
    input  logic              in_l,
    input  logic [1:0]        in_pp,
    input  logic [3:0]        in_src2,
    input  logic              in_reg_ext,
    input  logic              in_idx_ext,
    input  logic              in_base_ext,
    input  logic [7:0]        in_opcode,
    output logic              in_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic [2:0]        out_len
);
    instr_t                             instr;
    logic                               map_ok;
    logic                               short_ok;
    logic [MAX_BYTES-1:0][BYTE_W-1:0]   bytes;
    logic [LEN_W-1:0]                   len;
    logic                               busy;
    logic                               accept;
    logic                               err_q;

    // Gather the input fields into one record.
    always_comb begin
        instr = '{map: in_map, w: in_w, l: in_l, pp: in_pp, src2: in_src2,
                  reg_ext: in_reg_ext, idx_ext: in_idx_ext,
                  base_ext: in_base_ext, opc: in_opcode};
        in_ready = !busy;
        accept   = in_valid && !busy;
    end

    vpfx_form_sel u_sel (
        .instr    (instr),
        .map_ok   (map_ok),
        .short_ok (short_ok),
        .bytes    (bytes),
        .len      (len)
    );

    vpfx_byte_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && map_ok),
        .bytes     (bytes),
        .len       (len),
        .busy      (busy),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_len   (out_len)
    );

    // Register the one-cycle illegal-map pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= accept && !map_ok;
    end

    // Drive the error output.
    always_comb in_err = err_q;
endmodule

// File: rtl/vpfx_encoder_chk.sv
// Checker for the prefix encoder. It watches the top-level ports only and
// is attached with the bind statement at the end of this file.
module vpfx_encoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [4:0] in_map,
    input logic       in_err,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic [2:0] out_len
);
    logic first_q;

    // Track whether the next byte shown opens a new stream.
    always_ff @(posedge clk) begin
        if (!rst_n)                      first_q <= 1'b1;
        else if (out_valid && out_ready) first_q <= out_last;
    end

    p_lead_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (first_q && out_valid) |-> (out_data == 8'hC4 || out_data == 8'hC5));

    p_short_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (first_q && out_valid && out_data == 8'hC5) |-> (out_len == 3'd3));

    p_long_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (first_q && out_valid && out_data == 8'hC4) |-> (out_len == 3'd4));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_len)));

    p_idle_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    p_bad_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_map == 5'd0 || in_map > 5'd3)) |=>
            (in_err && !out_valid));

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_err |=> !in_err);
endmodule

bind vpfx_encoder vpfx_encoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_map    (in_map),
    .in_err    (in_err),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_len   (out_len)
);

// File: tb/vpfx_encoder_bench.sv
// Bench for the prefix encoder: a vector table walked by one loop, then
// directed tests for reset, back-pressure and illegal maps.
module vpfx_encoder_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [4:0]  map;
        logic        w;
        logic        l;
        logic [1:0]  pp;
        logic [3:0]  src2;
        logic        rx;
        logic        xx;
        logic        bx;
        logic [7:0]  opc;
        logic [2:0]  len;
        logic [31:0] exp;   // expected bytes, first byte in bits 31:24
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t TBL [NVEC] = '{
        '{5'd1, 1'b0, 1'b1, 2'd0, 4'd1,  1'b0, 1'b0, 1'b1, 8'h58, 3'd4, 32'hC4C17458},
        '{5'd1, 1'b0, 1'b1, 2'd0, 4'd1,  1'b0, 1'b0, 1'b0, 8'h58, 3'd3, 32'hC5F45800},
        '{5'd1, 1'b0, 1'b0, 2'd1, 4'd0,  1'b1, 1'b0, 1'b0, 8'h10, 3'd3, 32'hC5791000},
        '{5'd1, 1'b1, 1'b0, 2'd0, 4'd0,  1'b0, 1'b0, 1'b0, 8'h6F, 3'd4, 32'hC4E1F86F},
        '{5'd2, 1'b0, 1'b1, 2'd1, 4'd2,  1'b0, 1'b0, 1'b0, 8'h98, 3'd4, 32'hC4E26D98},
        '{5'd3, 1'b1, 1'b0, 2'd3, 4'd15, 1'b1, 1'b1, 1'b1, 8'h0F, 3'd4, 32'hC403830F},
        '{5'd1, 1'b0, 1'b1, 2'd2, 4'd9,  1'b0, 1'b1, 1'b0, 8'h51, 3'd4, 32'hC4A13651},
        '{5'd1, 1'b0, 1'b0, 2'd3, 4'd7,  1'b1, 1'b0, 1'b0, 8'hC2, 3'd3, 32'hC543C200}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [4:0] in_map = '0;
    logic       in_w = 1'b0;
    logic       in_l = 1'b0;
    logic [1:0] in_pp = '0;
    logic [3:0] in_src2 = '0;
    logic       in_reg_ext = 1'b0;
    logic       in_idx_ext = 1'b0;
    logic       in_base_ext = 1'b0;
    logic [7:0] in_opcode = '0;
    logic       in_err;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       out_last;
    logic [2:0] out_len;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vpfx_encoder u_vpfx_encoder (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one instruction on a falling edge and leave after the accepting edge.
    task automatic send(input vec_t v);
        @(negedge clk);
        in_map = v.map; in_w = v.w; in_l = v.l; in_pp = v.pp; in_src2 = v.src2;
        in_reg_ext = v.rx; in_idx_ext = v.xx; in_base_ext = v.bx; in_opcode = v.opc;
        in_valid = 1'b1;
        check("R8 ready when idle", 32'(in_ready), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Collect and check one stream. stall holds out_ready low on byte 0.
    task automatic collect(input vec_t v, input bit stall);
        for (int k = 0; k < int'(v.len); k++) begin
            logic [7:0] eb;
            eb = v.exp[31 - 8*k -: 8];
            check("R1/R2/R3 byte", {23'd0, out_valid, out_data}, {23'd0, 1'b1, eb});
            check("R6 last flag", 32'(out_last), 32'(k == int'(v.len) - 1));
            check("R5 length", 32'(out_len), 32'(v.len));
            check("R8 busy not ready", 32'(in_ready), 32'd0);
            if (stall && k == 0) begin
                out_ready = 1'b0;
                @(negedge clk);
                check("R7 hold under back-pressure", {23'd0, out_valid, out_data}, {23'd0, 1'b1, eb});
                out_ready = 1'b1;
            end
            @(negedge clk);
        end
        check("R8 ready after last", {31'd0, in_ready}, 32'd1);
        check("R8 idle after last", {31'd0, out_valid}, 32'd0);
    endtask

    // Send an illegal map code and check the error pulse with no output.
    task automatic bad_map(input logic [4:0] m);
        vec_t v;
        v = TBL[1];
        v.map = m;
        send(v);
        check("R9 error pulse", {30'd0, in_err, out_valid}, {30'd0, 1'b1, 1'b0});
        @(negedge clk);
        check("R9 pulse ends, no bytes", {29'd0, in_err, out_valid, in_ready}, {29'd0, 1'b0, 1'b0, 1'b1});
    endtask

    // Watchdog: an expired timer counts as a failure and ends the run.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 reset state", {29'd0, out_valid, in_ready, in_err}, {29'd0, 1'b0, 1'b1, 1'b0});

        for (int i = 0; i < NVEC; i++) begin
            send(TBL[i]);
            collect(TBL[i], 1'b0);
        end

        // R4: reg extension alone keeps the short form (vector 2, middle byte 0x79)
        send(TBL[2]);
        collect(TBL[2], 1'b1);
        // R7 back-pressure on a long stream
        send(TBL[5]);
        collect(TBL[5], 1'b1);

        // R9 illegal maps at both ends of the code range
        bad_map(5'd0);
        bad_map(5'd4);
        bad_map(5'd31);

        // A legal instruction after an error is still encoded normally.
        send(TBL[0]);
        collect(TBL[0], 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule